// File: doc/BRIEF.md
# PCM Serial Frame-Sync Port

This block is the digital serial side of a voice codec. It has two independent paths. The transmit path shifts an 8-bit PCM word out, most significant bit first. Its data pin is driven only while that word is on the line. The receive path shifts a word in from the data input and, at the start of each frame, hands the word from the previous frame to the decoder with a one-clock strobe. Each path has its own bit clock and its own 8 kHz frame-sync input.

Both inputs are sampled by a single system clock, which runs several times faster than the fastest bit clock. All of them are synchronous to that system clock. The block measures the width of each frame-sync pulse in bit-clock periods and selects short-frame or long-frame slot timing from it. The new timing takes effect from the following frame.

The transmit sync is timed out after two frame periods without a pulse. When that happens and receive sync continues, the port runs in receive-only half-channel mode and takes its timing from the receive sync. A power-down input that stays high stops both paths. An input that is low or toggling keeps the port running.

Top module: `pcm_frame_port`

## Requirements
- R1: In long-frame timing the transmit word leaves MSB first. Bit 7 is on `dx_data` from the bit-clock rising edge on which the transmit sync is first seen high. Each following rising edge presents the next lower bit, so bit 0 occupies slot 7 (slot n = n rising edges after the sync rise).
- R2: In short-frame timing the transmit word is delayed by one bit period. Bit 7 appears in slot 1 and bit 0 in slot 8.
- R3: `dx_drive` is 1 only during the eight slots of the transmit word and 0 at all other times. The pin is then treated as high-impedance.
- R4: The receive path samples `dr` on falling bit-clock edges, in the same slots as the transmit word for the current timing, MSB first. A completed word is presented on `rx_word`.
- R5: A receive sync rise pulses `dec_stb` high for exactly one system clock and updates `rx_word` at the same time. This happens only if a full word was received in the previous frame; otherwise there is no strobe.
- R6: A sync pulse seen high on exactly one rising bit-clock edge selects short timing (`long_mode`=0). A pulse seen on two or more edges selects long timing (`long_mode`=1). The choice is made when the pulse ends and applies from the next frame. After reset the timing is short.
- R7: While the transmit sync is present, only the transmit sync width sets the timing. The receive sync width is ignored.
- R8: When no transmit sync rise has occurred for 2*FRAME_CLKS system clocks, the transmit sync is absent. If the receive sync is present, `half_chan` is 1 and the receive sync width sets the timing.
- R9: When `pdn` is high for PDN_HOLD consecutive system clocks, the port is down: `dx_drive`=0, no strobe, no word is received and `running`=0. A `pdn` that toggles never powers the port down.
- R10: `running` is 1 when the port is not down and at least one frame sync is present. After reset `running`, `dx_drive`, `dec_stb`, `half_chan` and `long_mode` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling all inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| pdn | input | 1 | Power-down request, high level held |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fs | input | 1 | Transmit frame sync |
| tx_word | input | 8 | Word to transmit, captured at the sync rise |
| dx_data | output | 1 | Transmit serial data |
| dx_drive | output | 1 | Transmit pin drive enable (0 = high-impedance) |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fs | input | 1 | Receive frame sync |
| dr | input | 1 | Receive serial data |
| rx_word | output | 8 | Word handed to the decoder |
| dec_stb | output | 1 | One-clock decode strobe |
| long_mode | output | 1 | Current slot timing, 1 = long |
| half_chan | output | 1 | Receive-only half-channel mode |
| running | output | 1 | Port powered up with a sync present |

## Verification
A bit-clock edge is detected in the system clock cycle that samples it. The slot timers and the transmit bit therefore change one system clock after the bench drives a rising bit clock. The bench waits three more system clocks and reads `dx_data`/`dx_drive` at the end of each bit period, where every slot has settled.

`dec_stb` and `rx_word` are registered on the edge that detects the receive sync rise. They are read one system clock after the first rising bit clock of a frame, and the strobe is read again one bit period later to confirm that it has already dropped.

A timing change only shows in the next frame. The bench therefore predicts `long_mode` frame by frame from the widths it drove, and it uses the count of frames since the last transmit sync to decide when the receive width takes over.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  typedef enum logic {
    FS_SHORT = 1'b0,
    FS_LONG  = 1'b1
  } fs_mode_e;

  // A sync seen on two or more rising bit-clock edges selects long timing.
  function automatic fs_mode_e mode_of_width(input int unsigned width);
    return (width >= 2) ? FS_LONG : FS_SHORT;
  endfunction

endpackage

// File: rtl/pcm_edge_mon.sv
module pcm_edge_mon
  import pcm_port_pkg::*;
#(
  parameter int WIDTH_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fs,
  output logic step,
  output logic fall,
  output logic fs_rise,
  output logic pulse_end,
  output logic pulse_long
);
  localparam logic [WIDTH_W-1:0] WMAX = '1;

  logic               bclk_q;
  logic               fs_q;
  logic [WIDTH_W-1:0] wcnt;

  assign step       = bclk & ~bclk_q;
  assign fall       = ~bclk & bclk_q;
  assign fs_rise    = step & fs & ~fs_q;
  assign pulse_end  = step & ~fs & fs_q;
  assign pulse_long = (mode_of_width(int'(wcnt)) == FS_LONG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      fs_q   <= 1'b0;
      wcnt   <= '0;
    end else begin
      bclk_q <= bclk;
      if (step) begin
        fs_q <= fs;
        if (fs) wcnt <= !fs_q ? WIDTH_W'(1) : ((wcnt == WMAX) ? wcnt : wcnt + 1'b1);
      end
    end
  end

  // R6
  pulse_width_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_end |-> (wcnt != '0));

endmodule

// File: rtl/pcm_sync_watch.sv
module pcm_sync_watch #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seen,
  output logic absent
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] idle_cnt;

  assign absent = (idle_cnt == CW'(LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n)       idle_cnt <= CW'(LIMIT);
    else if (seen)    idle_cnt <= '0;
    else if (!absent) idle_cnt <= idle_cnt + 1'b1;
  end

  // R8
  sync_clears_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |=> !absent);

endmodule

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer #(
  parameter int WORD_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic                      step,
  input  logic                      start,
  input  logic                      long_mode,
  output logic                      active,
  output logic [$clog2(WORD_W)-1:0] idx
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_W - 1);

  logic pend;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      active <= 1'b0;
      pend   <= 1'b0;
      idx    <= '0;
    end else if (step) begin
      if (start && long_mode) begin
        active <= 1'b1;
        pend   <= 1'b0;
        idx    <= '0;
      end else if (start) begin
        active <= 1'b0;
        pend   <= 1'b1;
        idx    <= '0;
      end else if (pend) begin
        active <= 1'b1;
        pend   <= 1'b0;
        idx    <= '0;
      end else if (active) begin
        if (idx == LAST) active <= 1'b0;
        else             idx    <= idx + 1'b1;
      end
    end
  end

  // R3
  window_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && step && active && !start && idx == LAST) |=> !active);

  // R1
  window_opens_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> ($past(start) || $past(pend)));

endmodule

// File: rtl/pcm_frame_port.sv
module pcm_frame_port #(
  parameter int WORD_W     = 8,
  parameter int FRAME_CLKS = 512,
  parameter int PDN_HOLD   = 8,
  parameter int WIDTH_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pdn,
  input  logic              tx_bclk,
  input  logic              tx_fs,
  input  logic [WORD_W-1:0] tx_word,
  output logic              dx_data,
  output logic              dx_drive,
  input  logic              rx_bclk,
  input  logic              rx_fs,
  input  logic              dr,
  output logic [WORD_W-1:0] rx_word,
  output logic              dec_stb,
  output logic              long_mode,
  output logic              half_chan,
  output logic              running
);
  localparam int IDX_W   = $clog2(WORD_W);
  localparam int TIMEOUT = 2 * FRAME_CLKS;
  localparam int PDN_W   = $clog2(PDN_HOLD + 1);
  localparam int TXP     = 0;
  localparam int RXP     = 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_W - 1);

  function automatic logic pick_msb_first(input logic [WORD_W-1:0] w,
                                          input logic [IDX_W-1:0] slot);
    return w[WORD_W - 1 - int'(slot)];
  endfunction

  logic [1:0]       bclk_v, fs_v, step_v, fall_v, fs_rise_v;
  logic [1:0]       pulse_end_v, pulse_long_v, absent_v, active_v;
  logic [IDX_W-1:0] idx_v [2];

  logic [PDN_W-1:0]  pdn_cnt;
  logic              down;
  logic              mode_q;
  logic [WORD_W-1:0] tx_hold, rx_shift, rx_hold, rx_word_q;
  logic              rx_valid, dec_stb_q;

  assign bclk_v = {rx_bclk, tx_bclk};
  assign fs_v   = {rx_fs, tx_fs};

  for (genvar p = 0; p < 2; p++) begin : g_path
    pcm_edge_mon #(.WIDTH_W(WIDTH_W)) u_edge (
      .clk(clk), .rst_n(rst_n), .bclk(bclk_v[p]), .fs(fs_v[p]),
      .step(step_v[p]), .fall(fall_v[p]), .fs_rise(fs_rise_v[p]),
      .pulse_end(pulse_end_v[p]), .pulse_long(pulse_long_v[p])
    );
    pcm_sync_watch #(.LIMIT(TIMEOUT)) u_watch (
      .clk(clk), .rst_n(rst_n), .seen(fs_rise_v[p]), .absent(absent_v[p])
    );
    pcm_slot_timer #(.WORD_W(WORD_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .enable(!down), .step(step_v[p]),
      .start(fs_rise_v[p]), .long_mode(mode_q),
      .active(active_v[p]), .idx(idx_v[p])
    );
  end

  // Power-down: a level held high for PDN_HOLD clocks; a toggling input never gets there.
  assign down = (pdn_cnt == PDN_W'(PDN_HOLD));

  always_ff @(posedge clk) begin
    if (!rst_n || !pdn) pdn_cnt <= '0;
    else if (!down)     pdn_cnt <= pdn_cnt + 1'b1;
  end

  // Slot timing: transmit sync rules while present, receive sync otherwise.
  always_ff @(posedge clk) begin
    if (!rst_n)                                      mode_q <= 1'b0;
    else if (pulse_end_v[TXP] && !absent_v[TXP])     mode_q <= pulse_long_v[TXP];
    else if (pulse_end_v[RXP] && absent_v[TXP])      mode_q <= pulse_long_v[RXP];
  end

  // Transmit word is captured at the sync rise.
  always_ff @(posedge clk) begin
    if (!rst_n)                 tx_hold <= '0;
    else if (fs_rise_v[TXP])    tx_hold <= tx_word;
  end

  assign dx_drive = active_v[TXP];
  assign dx_data  = active_v[TXP] & pick_msb_first(tx_hold, idx_v[TXP]);

  // Receive shifter, hand-off register and decode strobe.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_shift  <= '0;
      rx_hold   <= '0;
      rx_word_q <= '0;
      rx_valid  <= 1'b0;
      dec_stb_q <= 1'b0;
    end else if (down) begin
      rx_valid  <= 1'b0;
      dec_stb_q <= 1'b0;
    end else begin
      dec_stb_q <= fs_rise_v[RXP] && rx_valid;
      if (fs_rise_v[RXP]) begin
        if (rx_valid) rx_word_q <= rx_hold;
        rx_valid <= 1'b0;
      end
      if (fall_v[RXP] && active_v[RXP]) begin
        rx_shift <= {rx_shift[WORD_W-2:0], dr};
        if (idx_v[RXP] == LAST) begin
          rx_hold  <= {rx_shift[WORD_W-2:0], dr};
          rx_valid <= 1'b1;
        end
      end
    end
  end

  assign rx_word   = rx_word_q;
  assign dec_stb   = dec_stb_q;
  assign long_mode = mode_q;
  assign running   = !down && !(absent_v[TXP] && absent_v[RXP]);
  assign half_chan = !down && absent_v[TXP] && !absent_v[RXP];

  // R5
  strobe_follows_rx_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stb |-> $past(fs_rise_v[RXP]));

  // R5
  strobe_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stb |=> !dec_stb);

  // R9
  down_stops_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    down |=> !dx_drive);

  // R9
  down_needs_pdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(down) |-> $past(pdn));

endmodule

// File: tb/tb_pcm_frame_port.sv
module tb_pcm_frame_port;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME_CLKS = 64;
  localparam int PDN_HOLD   = 4;
  localparam int NB         = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pdn_lvl = 1'b0, pdn_tog = 1'b0, tog_q = 1'b0;
  logic pdn;
  logic tx_bclk = 1'b0, tx_fs = 1'b0, rx_bclk = 1'b0, rx_fs = 1'b0, dr = 1'b0;
  logic [7:0] tx_word = '0;
  logic dx_data, dx_drive, dec_stb, long_mode, half_chan, running;
  logic [7:0] rx_word;

  int checks = 0, errors = 0;
  bit done = 0;
  bit cur_mode = 0, prev_valid = 0;
  logic [7:0] prev_rxw = '0;
  int fst = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) tog_q <= ~tog_q;
  assign pdn = pdn_lvl | (pdn_tog & tog_q);

  pcm_frame_port #(.WORD_W(8), .FRAME_CLKS(FRAME_CLKS), .PDN_HOLD(PDN_HOLD), .WIDTH_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .pdn(pdn), .tx_bclk(tx_bclk), .tx_fs(tx_fs), .tx_word(tx_word),
    .dx_data(dx_data), .dx_drive(dx_drive), .rx_bclk(rx_bclk), .rx_fs(rx_fs), .dr(dr),
    .rx_word(rx_word), .dec_stb(dec_stb), .long_mode(long_mode), .half_chan(half_chan),
    .running(running)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input bit tx_on, input bit rx_on, input int tw, input int rw,
                           input logic [7:0] txw, input logic [7:0] rxw, input bit dn);
    int slot;
    bit exp_stb, exp_drv;
    if (!tx_on) fst++;
    for (int b = 0; b < NB; b++) begin
      slot    = cur_mode ? b : b - 1;
      tx_word = txw;
      tx_bclk = 1'b1;
      rx_bclk = 1'b1;
      tx_fs   = tx_on && (b < tw);
      rx_fs   = rx_on && (b < rw);
      dr      = (slot >= 0 && slot < 8) ? rxw[7 - slot] : 1'b1;
      @(negedge clk);
      if (b == 0) begin
        exp_stb = rx_on && !dn && prev_valid;
        chk(dec_stb === exp_stb, dn ? "R9" : "R5", "decode strobe at rx sync", int'(dec_stb), int'(exp_stb));
        if (exp_stb) chk(rx_word === prev_rxw, "R4", "received word", int'(rx_word), int'(prev_rxw));
        chk(long_mode === cur_mode, "R6", "slot timing", int'(long_mode), int'(cur_mode));
      end
      if (b == 1) chk(dec_stb === 1'b0, "R5", "strobe one clock wide", int'(dec_stb), 0);
      @(negedge clk);
      tx_bclk = 1'b0;
      rx_bclk = 1'b0;
      @(negedge clk);
      @(negedge clk);
      exp_drv = tx_on && !dn && slot >= 0 && slot < 8;
      if (exp_drv)
        chk(dx_drive === 1'b1 && dx_data === txw[7 - slot], cur_mode ? "R1" : "R2",
            "transmit bit", int'({dx_drive, dx_data}), int'({1'b1, txw[7 - slot]}));
      else
        chk(dx_drive === 1'b0, dn ? "R9" : "R3", "pin released", int'(dx_drive), 0);
    end
    tx_fs = 1'b0;
    rx_fs = 1'b0;
    // R7: with transmit sync present only its width counts; R8: otherwise rx width after timeout
    if (tx_on) begin
      cur_mode = (tw >= 2);
      fst = 0;
    end else if (rx_on && fst >= 2) begin
      cur_mode = (rw >= 2);
    end
    prev_valid = rx_on && !dn;
    prev_rxw   = rxw;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(dx_drive === 1'b0, "R10", "reset drive", int'(dx_drive), 0);
    chk(dec_stb === 1'b0, "R10", "reset strobe", int'(dec_stb), 0);
    chk(running === 1'b0, "R10", "reset running", int'(running), 0);
    chk(long_mode === 1'b0, "R6", "reset timing short", int'(long_mode), 0);
    chk(half_chan === 1'b0, "R10", "reset half channel", int'(half_chan), 0);

    // Sweep of widths and words with both syncs; rx widths differ from tx widths (R7)
    for (int i = 0; i < 10; i++) begin
      int tws[10] = '{1, 1, 2, 3, 1, 4, 1, 2, 2, 1};
      run_frame(1, 1, tws[i], (i % 3 == 0) ? 3 : 1, 8'(i * 53 + 17), 8'(i * 91 + 5), 0);
      chk(running === 1'b1, "R10", "running with syncs", int'(running), 1);
      chk(half_chan === 1'b0, "R8", "no half channel with tx sync", int'(half_chan), 0);
    end

    // Half-channel: transmit sync stops, receive continues
    for (int j = 0; j < 4; j++) begin
      run_frame(0, 1, 0, (j % 2 == 1) ? 3 : 1, 8'hC3, 8'(j * 37 + 200), 0);
      if (fst >= 2) begin
        chk(half_chan === 1'b1, "R8", "half channel after timeout", int'(half_chan), 1);
        chk(running === 1'b1, "R10", "running on rx sync", int'(running), 1);
      end
    end
    run_frame(1, 1, 2, 1, 8'h5A, 8'hE1, 0);
    chk(half_chan === 1'b0, "R8", "tx sync back", int'(half_chan), 0);
    run_frame(1, 1, 1, 3, 8'h81, 8'h7E, 0);

    // Power-down held high
    pdn_lvl = 1'b1;
    repeat (PDN_HOLD + 2) @(negedge clk);
    run_frame(1, 1, 1, 1, 8'hFF, 8'h00, 1);
    chk(running === 1'b0, "R9", "powered down", int'(running), 0);
    pdn_lvl = 1'b0;
    repeat (2) @(negedge clk);

    // Toggling pdn keeps the port up
    pdn_tog = 1'b1;
    run_frame(1, 1, 2, 1, 8'h96, 8'h3C, 0);
    chk(running === 1'b1, "R9", "toggling pdn runs", int'(running), 1);
    pdn_tog = 1'b0;
    run_frame(1, 1, 1, 1, 8'h69, 8'hA5, 0);
    run_frame(1, 1, 1, 1, 8'h00, 8'hFF, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule